// File: doc/BRIEF.md
# Single-Cycle RISC Core

This block is a 32-bit processor core that retires one instruction per clock. In a single cycle it fetches the word the program counter points at, decodes it, reads two operands, runs the ALU and touches data memory if needed. The result is committed at the closing rising edge. It handles six register-register operations (add, sub, and, or, xor, set-less-than), word load, word store, branch-if-equal and an unconditional jump.

Both memories are small and word-indexed. While reset is held, a load port fills either the instruction memory or the data memory. A debug read port on the register file exposes architectural state, so a program's effect can be compared once it has run.

Top module: `scpu_top`

## Requirements
- R1: While reset is held, `pcOut` is 0x00400000 and every register reads zero. After reset, a non-control-flow instruction advances `pcOut` by 4 each clock, so the first edge after release gives 0x00400004.
- R2: Register-register instructions use opcode 000000. The funct field in bits [5:0] selects the operation: add 100000, sub 100010, and 100100, or 100101, xor 100110. The two sources are rs in bits [25:21] and rt in bits [20:16], and the result is written to rd in bits [15:11].
- R3: Set-less-than uses funct 101010. It writes 1 to rd when rs is less than rt as signed values, and 0 otherwise.
- R4: Register 0 always reads zero. A write aimed at it changes nothing.
- R5: A load (opcode 100011) writes into rt the data word at index bits [9:2] of rs plus the sign-extended immediate in bits [15:0].
- R6: A store (opcode 101011) writes rt into the data word addressed the same way as a load. It writes no register.
- R7: Branch-if-equal uses opcode 000100. When rs equals rt, the next PC is PC+4 plus the sign-extended immediate shifted left by 2; otherwise it is PC+4. It writes neither a register nor memory.
- R8: A jump (opcode 000010) sets the next PC to the top 4 bits of PC+4, then instruction bits [25:0], then two zero bits. It writes neither a register nor memory.
- R9: Operands are read combinationally during the cycle, and writes commit at the closing edge. An instruction that names the same register as both source and destination therefore uses the old value.
- R10: With reset held and `loadEn` high, `loadData` is written at the next rising edge to word `loadAddr` of the data memory when `loadToData` is 1. It goes to the instruction memory when `loadToData` is 0. Instruction word k is fetched at address 0x00400000 + 4k, modulo the memory size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; loading is allowed only while it is high |
| loadEn | input | 1 | Load port write strobe |
| loadToData | input | 1 | Load target: 1 for data memory, 0 for instruction memory |
| loadAddr | input | 8 | Word index for the load port |
| loadData | input | 32 | Word written through the load port |
| dbgReg | input | 5 | Register number for the debug read port |
| dbgData | output | 32 | Current value of the register selected by `dbgReg` |
| pcOut | output | 32 | Current program counter |

## Verification
Two functions can land in the same cycle. The first case is reading an operand and writing that same register: `add r3,r3,r3` must double the old value. The second case is a store followed at once by a load of the same word, where the load must return the value just written. The directed program places both cases back to back, and the random programs create them by chance with a small register pool and a small address range. After each program, the bench judges every register against a bench-side instruction model, and it compares the PC with that model every cycle.

// File: rtl/scpu_pkg.sv
package scpu_pkg;
  localparam int REG_AW = 5;

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_LW    = 6'b100011;
  localparam logic [5:0] OP_SW    = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_J     = 6'b000010;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_XOR = 6'b100110;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_XOR = 3'b011,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_op_e;

  typedef enum logic [1:0] {
    CLS_MEM   = 2'b00,
    CLS_CMP   = 2'b01,
    CLS_FUNCT = 2'b10
  } alu_class_e;

  typedef struct packed {
    logic    regDst;
    logic    aluSrc;
    logic    memToReg;
    logic    regWrite;
    logic    memRead;
    logic    memWrite;
    logic    branch;
    logic    jump;
    alu_op_e aluCtl;
  } ctl_t;
endpackage

// File: rtl/scpu_control.sv
module scpu_control
  import scpu_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctl_t       ctl
);
  alu_class_e aluClass;

  always_comb begin
    ctl      = '0;
    aluClass = CLS_MEM;
    case (opcode)
      OP_RTYPE: begin
        ctl.regDst   = 1'b1;
        ctl.regWrite = 1'b1;
        aluClass     = CLS_FUNCT;
      end
      OP_LW: begin
        ctl.aluSrc   = 1'b1;
        ctl.memToReg = 1'b1;
        ctl.regWrite = 1'b1;
        ctl.memRead  = 1'b1;
      end
      OP_SW: begin
        ctl.aluSrc   = 1'b1;
        ctl.memWrite = 1'b1;
      end
      OP_BEQ: begin
        ctl.branch = 1'b1;
        aluClass   = CLS_CMP;
      end
      OP_J:    ctl.jump = 1'b1;
      default: ;
    endcase

    case (aluClass)
      CLS_CMP: ctl.aluCtl = ALU_SUB;
      CLS_FUNCT: begin
        case (funct)
          FN_SUB:  ctl.aluCtl = ALU_SUB;
          FN_AND:  ctl.aluCtl = ALU_AND;
          FN_OR:   ctl.aluCtl = ALU_OR;
          FN_XOR:  ctl.aluCtl = ALU_XOR;
          FN_SLT:  ctl.aluCtl = ALU_SLT;
          default: ctl.aluCtl = ALU_ADD;
        endcase
      end
      default: ctl.aluCtl = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/scpu_regfile.sv
module scpu_regfile
  import scpu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] rdAddrA,
  input  logic [REG_AW-1:0] rdAddrB,
  input  logic [REG_AW-1:0] rdAddrDbg,
  output logic [XLEN-1:0]   rdDataA,
  output logic [XLEN-1:0]   rdDataB,
  output logic [XLEN-1:0]   rdDataDbg,
  input  logic              wrEn,
  input  logic [REG_AW-1:0] wrAddr,
  input  logic [XLEN-1:0]   wrData
);
  localparam int NREG = 1 << REG_AW;

  logic [XLEN-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wrEn && (wrAddr != '0)) begin
      regs[wrAddr] <= wrData;
    end
  end

  assign rdDataA   = (rdAddrA   == '0) ? '0 : regs[rdAddrA];
  assign rdDataB   = (rdAddrB   == '0) ? '0 : regs[rdAddrB];
  assign rdDataDbg = (rdAddrDbg == '0) ? '0 : regs[rdAddrDbg];
endmodule

// File: rtl/scpu_alu.sv
module scpu_alu
  import scpu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] opA,
  input  logic [XLEN-1:0] opB,
  input  alu_op_e         op,
  output logic [XLEN-1:0] result,
  output logic            zero
);
  always_comb begin
    case (op)
      ALU_AND: result = opA & opB;
      ALU_OR:  result = opA | opB;
      ALU_XOR: result = opA ^ opB;
      ALU_SUB: result = opA - opB;
      ALU_SLT: result = {{(XLEN-1){1'b0}}, ($signed(opA) < $signed(opB))};
      default: result = opA + opB;
    endcase
  end

  assign zero = (result == '0);
endmodule

// File: rtl/scpu_datapath.sv
module scpu_datapath
  import scpu_pkg::*;
#(
  parameter int          XLEN      = 32,
  parameter int          MEM_WORDS = 256,
  parameter logic [31:0] RESET_PC  = 32'h0040_0000
) (
  input  logic                         clk,
  input  logic                         rst,
  input  ctl_t                         ctl,
  output logic [31:0]                  instr,
  input  logic                         loadEn,
  input  logic                         loadToData,
  input  logic [$clog2(MEM_WORDS)-1:0] loadAddr,
  input  logic [31:0]                  loadData,
  input  logic [REG_AW-1:0]            dbgReg,
  output logic [XLEN-1:0]              dbgData,
  output logic [XLEN-1:0]              pcOut
);
  localparam int IDX_W = $clog2(MEM_WORDS);

  logic [31:0]       imem [MEM_WORDS];
  logic [XLEN-1:0]   dmem [MEM_WORDS];
  logic [XLEN-1:0]   pc, pcPlus4, brTarget, jmpTarget, pcNext;
  logic [XLEN-1:0]   rsVal, rtVal, immExt, aluB, aluY, memData, wbData;
  logic [REG_AW-1:0] wrAddr;
  logic              aluZero;
  logic [IDX_W-1:0]  dIdx;
  logic              unusedAddrBits;

  assign instr = imem[pc[IDX_W+1:2]];

  always_ff @(posedge clk) begin
    if (rst && loadEn && !loadToData) imem[loadAddr] <= loadData;
  end

  scpu_regfile #(.XLEN(XLEN)) u_regs (
    .clk(clk), .rst(rst),
    .rdAddrA(instr[25:21]), .rdAddrB(instr[20:16]), .rdAddrDbg(dbgReg),
    .rdDataA(rsVal), .rdDataB(rtVal), .rdDataDbg(dbgData),
    .wrEn(ctl.regWrite), .wrAddr(wrAddr), .wrData(wbData)
  );

  assign immExt = {{(XLEN-16){instr[15]}}, instr[15:0]};
  assign aluB   = ctl.aluSrc ? immExt : rtVal;

  scpu_alu #(.XLEN(XLEN)) u_alu (
    .opA(rsVal), .opB(aluB), .op(ctl.aluCtl), .result(aluY), .zero(aluZero)
  );

  assign dIdx           = aluY[IDX_W+1:2];
  assign unusedAddrBits = ^{aluY[XLEN-1:IDX_W+2], aluY[1:0]};
  assign memData        = ctl.memRead ? dmem[dIdx] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      if (loadEn && loadToData) dmem[loadAddr] <= loadData;
    end else if (ctl.memWrite) begin
      dmem[dIdx] <= rtVal;
    end
  end

  assign wrAddr = ctl.regDst ? instr[15:11] : instr[20:16];
  assign wbData = ctl.memToReg ? memData : aluY;

  assign pcPlus4   = pc + XLEN'(4);
  assign brTarget  = pcPlus4 + {immExt[XLEN-3:0], 2'b00};
  assign jmpTarget = {pcPlus4[XLEN-1:28], instr[25:0], 2'b00};

  always_comb begin
    if (ctl.jump)                   pcNext = jmpTarget;
    else if (ctl.branch && aluZero) pcNext = brTarget;
    else                            pcNext = pcPlus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= RESET_PC;
    else     pc <= pcNext;
  end

  assign pcOut = pc;
endmodule

// File: rtl/scpu_top.sv
module scpu_top
  import scpu_pkg::*;
#(
  parameter int          MEM_WORDS = 256,
  parameter logic [31:0] RESET_PC  = 32'h0040_0000
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         loadEn,
  input  logic                         loadToData,
  input  logic [$clog2(MEM_WORDS)-1:0] loadAddr,
  input  logic [31:0]                  loadData,
  input  logic [REG_AW-1:0]            dbgReg,
  output logic [31:0]                  dbgData,
  output logic [31:0]                  pcOut
);
  ctl_t        ctl;
  logic [31:0] instr;
  logic        unusedFields;

  assign unusedFields = ^instr[25:6];

  scpu_control u_ctl (
    .opcode(instr[31:26]), .funct(instr[5:0]), .ctl(ctl)
  );

  scpu_datapath #(.XLEN(32), .MEM_WORDS(MEM_WORDS), .RESET_PC(RESET_PC)) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .instr(instr),
    .loadEn(loadEn), .loadToData(loadToData), .loadAddr(loadAddr), .loadData(loadData),
    .dbgReg(dbgReg), .dbgData(dbgData), .pcOut(pcOut)
  );
endmodule

// File: rtl/scpu_checker.sv
module scpu_checker
  import scpu_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0040_0000
) (
  input logic              clk,
  input logic              rst,
  input logic [31:0]       pcOut,
  input logic [31:0]       instr,
  input ctl_t              ctl,
  input logic [REG_AW-1:0] dbgReg,
  input logic [31:0]       dbgData
);
  p_pc_start_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> pcOut == RESET_PC);

  p_pc_step_r1: assert property (@(posedge clk) disable iff (rst)
    (instr[31:26] != OP_BEQ && instr[31:26] != OP_J) |=> pcOut == $past(pcOut) + 32'd4);

  p_jump_index_r8: assert property (@(posedge clk) disable iff (rst)
    (instr[31:26] == OP_J) |=> pcOut[27:0] == {$past(instr[25:0]), 2'b00});

  p_no_regwrite_r6: assert property (@(posedge clk) disable iff (rst)
    (instr[31:26] == OP_SW || instr[31:26] == OP_BEQ || instr[31:26] == OP_J) |-> !ctl.regWrite);

  p_store_only_r7: assert property (@(posedge clk) disable iff (rst)
    ctl.memWrite |-> instr[31:26] == OP_SW);

  p_zero_reg_r4: assert property (@(posedge clk) disable iff (rst)
    (dbgReg == '0) |-> dbgData == 32'd0);
endmodule

bind scpu_top scpu_checker #(.RESET_PC(RESET_PC)) u_chk (
  .clk(clk), .rst(rst), .pcOut(pcOut), .instr(instr), .ctl(ctl),
  .dbgReg(dbgReg), .dbgData(dbgData)
);

// File: tb/scpu_top_bench.sv
`timescale 1ns/1ps
module scpu_top_bench;
  localparam logic [31:0] PC0 = 32'h0040_0000;
  localparam logic [31:0] HALT = {6'b000100, 5'd0, 5'd0, 16'hFFFF};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        loadEn = 1'b0;
  logic        loadToData = 1'b0;
  logic [7:0]  loadAddr = '0;
  logic [31:0] loadData = '0;
  logic [4:0]  dbgReg = '0;
  logic [31:0] dbgData, pcOut;

  int nChecks = 0;
  int nFail = 0;

  logic [31:0] mReg [32];
  logic [31:0] mDm  [256];
  logic [31:0] mIm  [256];
  logic [31:0] mPc;

  always #2.5 clk = ~clk;

  scpu_top u_scpu_top (
    .clk(clk), .rst(rst), .loadEn(loadEn), .loadToData(loadToData),
    .loadAddr(loadAddr), .loadData(loadData), .dbgReg(dbgReg),
    .dbgData(dbgData), .pcOut(pcOut)
  );

  function automatic logic [31:0] encR(int rd, int rs, int rt, logic [5:0] fn);
    return {6'b000000, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction

  function automatic logic [31:0] encI(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, rs[4:0], rt[4:0], imm};
  endfunction

  function automatic logic [31:0] encJ(int wordIdx);
    logic [31:0] tgt;
    tgt = PC0 + 32'(wordIdx * 4);
    return {6'b000010, tgt[27:2]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic readReg(int idx, output logic [31:0] v);
    dbgReg = idx[4:0];
    #0.2;
    v = dbgData;
  endtask

  task automatic modelStep();
    logic [31:0] ins, a, b, r, sx, addr, nxt;
    int rs, rt, rd;
    ins = mIm[mPc[9:2]];
    rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
    a = mReg[rs]; b = mReg[rt];
    sx = {{16{ins[15]}}, ins[15:0]};
    addr = a + sx;
    nxt = mPc + 32'd4;
    case (ins[31:26])
      6'b000000: begin
        case (ins[5:0])
          6'b100010: r = a - b;
          6'b100100: r = a & b;
          6'b100101: r = a | b;
          6'b100110: r = a ^ b;
          6'b101010: r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
          default:   r = a + b;
        endcase
        if (rd != 0) mReg[rd] = r;
      end
      6'b100011: if (rt != 0) mReg[rt] = mDm[addr[9:2]];
      6'b101011: mDm[addr[9:2]] = b;
      6'b000100: if (a == b) nxt = mPc + 32'd4 + {sx[29:0], 2'b00};
      6'b000010: nxt = {nxt[31:28], ins[25:0], 2'b00};
      default: ;
    endcase
    mPc = nxt;
  endtask

  // Loads both memories under reset (R10), checks reset state (R1), runs in lockstep.
  task automatic runProg(int cycles, string tag);
    logic [31:0] v;
    rst = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 256; i++) begin
      loadEn = 1'b1; loadToData = 1'b0; loadAddr = i[7:0]; loadData = mIm[i];
      @(negedge clk);
      loadToData = 1'b1; loadData = mDm[i];
      @(negedge clk);
    end
    loadEn = 1'b0;
    for (int i = 0; i < 32; i++) mReg[i] = '0;
    mPc = PC0;
    chk("R1 reset pc", pcOut, PC0);
    for (int i = 0; i < 32; i += 7) begin
      readReg(i, v);
      chk("R1 reset reg", v, 32'd0);
    end
    @(negedge clk);
    rst = 1'b0;
    for (int c = 0; c < cycles; c++) begin
      @(posedge clk);
      modelStep();
      @(negedge clk);
      if (c == 0 && mIm[0][31:26] != 6'b000100 && mIm[0][31:26] != 6'b000010)
        chk("R1 first step", pcOut, 32'h0040_0004);
      chk("R7/R8 pc flow", pcOut, mPc);
    end
    for (int i = 0; i < 32; i++) begin
      readReg(i, v);
      chk(tag, v, mReg[i]);
    end
  endtask

  initial begin
    logic [31:0] v, d0, d1, d2, d3, dTop, seedDummy;
    seedDummy = $urandom(32'd2024);

    // ---------------- directed program ----------------
    for (int i = 0; i < 256; i++) begin
      mIm[i] = HALT;
      mDm[i] = $urandom;
    end
    mDm[0] = 32'h0000_0005;
    mDm[1] = 32'h8000_0003;
    mDm[2] = 32'h0F0F_33CC;
    mDm[3] = 32'h00FF_F0F0;
    d0 = mDm[0]; d1 = mDm[1]; d2 = mDm[2]; d3 = mDm[3]; dTop = mDm[255];
    mIm[0]  = encI(6'b100011, 0, 1, 16'd0);
    mIm[1]  = encI(6'b100011, 0, 2, 16'd4);
    mIm[2]  = encI(6'b100011, 0, 3, 16'd8);
    mIm[3]  = encI(6'b100011, 0, 4, 16'd12);
    mIm[4]  = encR(5, 1, 2, 6'b100000);
    mIm[5]  = encR(6, 1, 2, 6'b100010);
    mIm[6]  = encR(7, 3, 4, 6'b100100);
    mIm[7]  = encR(8, 3, 4, 6'b100101);
    mIm[8]  = encR(9, 1, 3, 6'b100110);
    mIm[9]  = encR(10, 2, 1, 6'b101010);
    mIm[10] = encR(11, 1, 2, 6'b101010);
    mIm[11] = encR(0, 1, 1, 6'b100000);
    mIm[12] = encR(3, 3, 3, 6'b100000);
    mIm[13] = encI(6'b101011, 0, 5, 16'd64);
    mIm[14] = encI(6'b100011, 0, 12, 16'd64);
    mIm[15] = encI(6'b100011, 0, 13, 16'hFFFC);
    mIm[16] = encI(6'b000100, 1, 1, 16'd2);
    mIm[17] = encR(20, 1, 1, 6'b100000);
    mIm[18] = encR(21, 1, 1, 6'b100000);
    mIm[19] = encI(6'b000100, 1, 2, 16'd5);
    mIm[20] = encJ(23);
    mIm[21] = encR(22, 1, 1, 6'b100000);
    mIm[22] = encR(23, 1, 1, 6'b100000);
    mIm[23] = encI(6'b101011, 0, 1, 16'd8);
    mIm[24] = encI(6'b100011, 0, 15, 16'd8);
    runProg(40, "R2 directed regs");

    readReg(5, v);  chk("R2 add", v, d0 + d1);
    readReg(6, v);  chk("R2 sub", v, d0 - d1);
    readReg(7, v);  chk("R2 and", v, d2 & d3);
    readReg(8, v);  chk("R2 or", v, d2 | d3);
    readReg(9, v);  chk("R2 xor", v, d0 ^ d2);
    readReg(10, v); chk("R3 slt negative<positive", v, 32'd1);
    readReg(11, v); chk("R3 slt positive<negative", v, 32'd0);
    readReg(0, v);  chk("R4 r0 stays zero", v, 32'd0);
    readReg(3, v);  chk("R9 same reg src/dst", v, d2 + d2);
    readReg(12, v); chk("R6 store then load", v, d0 + d1);
    readReg(13, v); chk("R5 negative offset wraps", v, dTop);
    readReg(20, v); chk("R7 taken branch skips", v, 32'd0);
    readReg(21, v); chk("R7 taken branch skips", v, 32'd0);
    readReg(22, v); chk("R8 jump skips", v, 32'd0);
    readReg(23, v); chk("R8 jump skips", v, 32'd0);
    readReg(15, v); chk("R6 store overwrite", v, d0);
    readReg(1, v);  chk("R10 data load port", v, d0);
    chk("R7 halt loop pc", pcOut, PC0 + 32'd100);

    // ---------------- random programs ----------------
    for (int p = 0; p < 6; p++) begin
      for (int i = 0; i < 256; i++) begin
        mIm[i] = HALT;
        mDm[i] = $urandom;
        if (($urandom % 4) == 0) mDm[i] = $urandom % 8;
      end
      for (int i = 0; i < 8; i++)
        mIm[i] = encI(6'b100011, 0, i + 1, 16'(4 * ($urandom % 16)));
      for (int i = 8; i < 28; i++) begin
        int k, rs, rt, rd;
        logic [5:0] fn;
        k  = int'($urandom % 10);
        rs = int'($urandom % 10);
        rt = (($urandom % 3) == 0) ? rs : int'($urandom % 10);
        rd = int'($urandom % 10);
        case ($urandom % 6)
          0: fn = 6'b100000;
          1: fn = 6'b100010;
          2: fn = 6'b100100;
          3: fn = 6'b100101;
          4: fn = 6'b100110;
          default: fn = 6'b101010;
        endcase
        if (k < 6)       mIm[i] = encR(rd, rs, rt, fn);
        else if (k == 6) mIm[i] = encI(6'b100011, 0, rd, 16'(4 * ($urandom % 16)));
        else if (k == 7) mIm[i] = encI(6'b101011, 0, rt, 16'(4 * ($urandom % 16)));
        else if (k == 8) mIm[i] = encI(6'b000100, rs, rt, 16'($urandom % 2));
        else             mIm[i] = encJ(i + 1 + int'($urandom % 2));
      end
      runProg(40, "R2/R5/R6 random regs");
    end

    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    #1000000;
    nFail++;
    nChecks++;
    $display("FAIL watchdog: actual running expected done");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule